// File: doc/BRIEF.md
# Skewed Inertial Inverter Delay

This block is a clocked single-bit inverter whose two output edges take different numbers of clock cycles. The falling output edge is slower than the rising one. The gap between the two delays serves as an inertial window, so a high input pulse that is too short to justify a falling output edge never appears at the output.

The block never schedules an output edge that it may later have to cancel. It first builds a qualified copy of the input. That copy follows the input down in the same cycle, but it goes up only after the input has held high for longer than the inertial window. The inverse of the qualified copy then passes through a fixed-length shift line. Every pending edge sits in that line, so a train of edges spaced closer than the delay comes out intact.

Both delays are parameters, and elaboration stops if the fall delay is smaller than the rise delay. Edge indices below count rising clock edges, and the input value taken at an edge is the sample for that edge. The window is W = FALL_CYC - RISE_CYC, which is 4 with the defaults.

Top module: `skew_inv_delay`

## Requirements
- R1: While `rst` is high, `dout` is 1 after every clock edge. After reset is released, `dout` stays 1 until the input qualifies, as R2 describes.
- R2: Suppose `din` is first sampled high at edge k and stays high through edge k+W. Then `dout` is 0 after edge k+FALL_CYC (k+14 with the defaults).
- R3: Suppose `din` is first sampled low at edge j and the output was low or pending low. Then `dout` is 1 after edge j+RISE_CYC (j+10 with the defaults).
- R4: A high input run of at most W consecutive samples changes nothing at `dout`. For example, an input that rises at edge 0 and falls at edge 3 leaves `dout` high throughout.
- R5: Several pending output edges are held at once. A train of high runs longer than W, separated by short gaps, comes out with each edge at its own delay.
- R6: Low input pulses are not filtered. A single low sample inside a long high run yields a high output pulse starting RISE_CYC edges later. That pulse lasts W+1 cycles, because the input must requalify before the output can fall again.
- R7: For any input sequence, `dout` after edge n is the inverse of the qualified input at edge n-RISE_CYC. The qualified input at edge m is 1 only when the samples m-W through m are all high and all taken after reset release. Otherwise the qualified input is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input |
| dout | output | 1 | Delayed, inverted and filtered output |

## Verification
Wrong qualification logic would show at `dout` exactly RISE_CYC cycles after the faulty cycle. It would appear either as a low output pulse after a short high input run, or as a missing or shifted falling edge after a long run. A fault in the shift line would shift edges or merge close edges. That shows up in pulse trains whose gaps are shorter than the delay, within one delay length of the stimulus. Every cycle is compared against the edge-accurate model of R7, so a one-cycle shift is caught on the first affected edge.

// File: rtl/skew_inv_delay.sv
module skew_inv_delay #(
  parameter int RISE_CYC = 10,
  parameter int FALL_CYC = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int WIN = FALL_CYC - RISE_CYC;
  localparam int CW  = (WIN < 1) ? 1 : $clog2(WIN + 1);

  if (FALL_CYC < RISE_CYC) begin : g_bad_order
    $error("skew_inv_delay: FALL_CYC must be at least RISE_CYC");
  end
  if (RISE_CYC < 1) begin : g_bad_rise
    $error("skew_inv_delay: RISE_CYC must be at least 1");
  end

  logic [CW-1:0]       run;
  logic                qual;
  logic [RISE_CYC-1:0] line;

  assign qual = din && (run >= CW'(WIN));

  always_ff @(posedge clk) begin
    if (rst || !din)          run <= '0;
    else if (run != CW'(WIN)) run <= run + 1'b1;
  end

  if (RISE_CYC == 1) begin : g_line1
    always_ff @(posedge clk) begin
      if (rst) line <= '0;
      else     line <= qual;
    end
  end else begin : g_lineN
    always_ff @(posedge clk) begin
      if (rst) line <= '0;
      else     line <= {line[RISE_CYC-2:0], qual};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b1;
    else     dout <= ~line[RISE_CYC-1];
  end
endmodule

// File: rtl/skew_inv_delay_chk.sv
module skew_inv_delay_chk #(
  parameter int RISE_CYC = 10,
  parameter int FALL_CYC = 14
) (
  input logic clk,
  input logic rst,
  input logic din,
  input logic dout,
  input logic head
);
  localparam int WIN = FALL_CYC - RISE_CYC;

  int            hi_cnt;
  logic [RISE_CYC:0] lo_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= 0;
      lo_hist <= '0;
    end else begin
      hi_cnt  <= !din ? 0 : ((hi_cnt < WIN) ? hi_cnt + 1 : hi_cnt);
      lo_hist <= {lo_hist[RISE_CYC-1:0], !din};
    end
  end

  AST_RESET_OUT_HIGH: assert property (@(posedge clk)
    rst |=> dout);  // R1
  AST_SHORT_RUN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!din || hi_cnt < WIN) |=> !head);  // R4
  AST_LONG_RUN_PASSES: assert property (@(posedge clk) disable iff (rst)
    (din && hi_cnt >= WIN) |=> head);  // R2
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(dout) |-> !lo_hist[RISE_CYC]);  // R2
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> lo_hist[RISE_CYC]);  // R3
endmodule

bind skew_inv_delay skew_inv_delay_chk #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_chk (
  .clk(clk), .rst(rst), .din(din), .dout(dout), .head(line[0])
);

// File: tb/skew_inv_delay_bench.sv
module skew_inv_delay_bench;
  localparam int RISE = 10;
  localparam int FALL = 14;
  localparam int W    = FALL - RISE;
  localparam int HMAX = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  bit done = 1'b0;
  bit hist [HMAX];
  string req = "R1";

  always #2.5 clk = ~clk;

  skew_inv_delay #(.RISE_CYC(RISE), .FALL_CYC(FALL)) u_skew_inv_delay (
    .clk(clk), .rst(rst), .din(din), .dout(dout)
  );

  function automatic bit qual_at(int m);
    for (int i = 0; i <= W; i++) begin
      if (m - i < 0) return 1'b0;
      if (!hist[m-i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit exp_out(int n);
    if (n - RISE < 0) return 1'b1;
    return !qual_at(n - RISE);
  endfunction

  task automatic check(bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: dout=%0b expected=%0b", req, idx, act, exp);
    end
  endtask

  task automatic step(bit v);
    din = v;
    if (idx < HMAX) hist[idx] = v;
    @(posedge clk);
    #1;
    if (idx < HMAX) check(dout, exp_out(idx));
    idx++;
    @(negedge clk);
  endtask

  task automatic run(bit v, int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired: run did not complete");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    req = "R1";
    din = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1;
      check(dout, 1'b1);
      @(negedge clk);
    end
    rst = 1'b0;
    req = "R1";
    run(1'b0, 15);
    req = "R4";
    for (int wdt = 1; wdt <= W; wdt++) begin
      run(1'b1, wdt);
      run(1'b0, 20);
    end
    req = "R2";
    run(1'b1, 30);
    req = "R3";
    run(1'b0, 30);
    req = "R2";
    run(1'b1, W + 1);
    run(1'b0, 25);
    req = "R5";
    run(1'b1, 6); run(1'b0, 3); run(1'b1, 7); run(1'b0, 2);
    run(1'b1, 9); run(1'b0, 1); run(1'b1, 5); run(1'b0, 25);
    req = "R6";
    run(1'b1, 25); run(1'b0, 1); run(1'b1, 30); run(1'b0, 25);
    req = "R7";
    for (int s = 0; s < 300; s++) begin
      run(1'b1, 1 + ($urandom % 9));
      run(1'b0, 1 + ($urandom % 14));
    end
    run(1'b0, 20);
    finish_up();
  end
endmodule